// File: doc/BRIEF.md
# Sync-Armed Function Controller with Shadow Coefficient Transfer

This block decides when each of eight sync-controlled functions may update its operating state. Each function holds a 2-bit source code. The code names the event that arms it: hardware sync pin A, hardware sync pin B, or a software trigger. When the selected event arrives, the function emits a one-cycle update strobe. The function then drops back to unconfigured, so the next event needs a fresh configuration write first.

Four functions are datapath syncs: receive (index 0), stage (1), decimation (2) and interpolation (3). These respond only to the hardware pins. Sample processing (`run_enable`) stays low until all four have fired once. Four are ancillary syncs: delay (4), cancellation (5), resource (6) and output gain (7). These also accept the software trigger.

Cancellation coefficients are written by the host into a shadow RAM. When the cancellation strobe fires, a copy engine walks the shadow RAM one address per clock and writes each entry into every bank selected by an 8-bit bank mask. Resource counts for four stages are staged by the host and become active on the resource strobe. Each active count sets a per-stage peak capacity of four peaks per assigned bank.

Top module: `sync_ctrl_top`

Host address map (6-bit address, 32-bit data):
- 0..7: source code of function 0..7 in data[1:0]. The codes are 0 never, 1 pin A, 2 pin B, 3 software.
- 8: bank mask in data[7:0].
- 9: copy length in data[4:0] and complex mode in data[16].
- 10: software trigger, active when data[0] is 1.
- 12..15: resource count of stage 0..3 in data[3:0].
- 32..47: shadow entry, with I in data[15:0] and Q in data[31:16].

Each function has a small FSM with two states, UNCFG and ARMED:
- A config write with a usable code moves UNCFG to ARMED.
- An event that matches the stored code moves ARMED to UNCFG, and the strobe fires.
- A config write in ARMED reloads the code, or returns to UNCFG if the code is unusable.

The copy engine has two states, IDLE and COPY:
- The cancellation strobe with a nonzero length moves IDLE to COPY.
- Writing the last entry moves COPY back to IDLE.

## Requirements
- R1: After reset all update strobes, `run_enable`, `bank_we`, `host_stall` and `peak_cap` are zero.
- R2: A rising edge on a sync pin produces exactly one strobe, on each armed function whose code selects that pin. Holding the pin high produces no further strobes.
- R3: Writing 1 to data[0] at address 10 produces one strobe on each armed ancillary function with code 3.
- R4: Datapath functions (0 to 3) treat code 3 as never and ignore the software trigger.
- R5: An event reaching a function that is unconfigured, or configured with code 0, is ignored. A fired function ignores later events until it is written again.
- R6: `run_enable` rises only after functions 0 to 3 have each strobed, and then stays high.
- R7: Shadow RAM writes do not change any bank until the cancellation strobe (function 5) fires.
- R8: After the cancellation strobe, shadow entries 0 to length-1 are written, one per cycle, to every bank whose bit is set in the mask. No other bank is written, and no entry at or beyond the length is written.
- R9: In complex mode (data[16]=1 at address 9) bank Q data carries the shadow Q word. In real mode bank Q data is zero.
- R10: While a copy runs, `host_stall` is high and shadow writes are dropped.
- R11: On the resource strobe (function 6), `peak_cap` field s (bits 6s+5:6s) becomes 4 times that stage's staged count. Counts above 8 are taken as 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write enable |
| host_addr | input | 6 | Host write address |
| host_wdata | input | 32 | Host write data |
| host_stall | output | 1 | Copy in progress; shadow writes dropped |
| sync_a | input | 1 | Hardware sync pin A (asynchronous) |
| sync_b | input | 1 | Hardware sync pin B (asynchronous) |
| upd_strobe | output | 8 | One-cycle update strobe per function |
| run_enable | output | 1 | All datapath syncs done; processing allowed |
| bank_we | output | 8 | Per-bank write enable |
| bank_addr | output | 4 | Bank write address |
| bank_wdata_i | output | 16 | Bank I write data |
| bank_wdata_q | output | 16 | Bank Q write data |
| peak_cap | output | 24 | Per-stage peak capacity, 6 bits per stage |

## Verification
A function left wrongly in ARMED or UNCFG shows up at `upd_strobe` within three clocks of a pin edge, or two clocks of a software trigger. It appears either as a missing strobe or as a second strobe from one configuration. A wrong copy count, start or mask shows up on `bank_we` and `bank_addr` during the copy window. Captured bank contents then differ at a specific entry, so the bench compares each bank word by word against the shadow pattern. A stale resource count appears on `peak_cap` in the cycle after the resource strobe.

// File: rtl/sync_pkg.sv
package sync_pkg;
    typedef enum logic [1:0] {
        SRC_NEVER = 2'd0,
        SRC_PIN_A = 2'd1,
        SRC_PIN_B = 2'd2,
        SRC_SOFT  = 2'd3
    } sync_src_e;

    typedef enum logic {
        ARM_UNCFG = 1'b0,
        ARM_ARMED = 1'b1
    } arm_state_e;

    typedef enum logic {
        CP_IDLE = 1'b0,
        CP_COPY = 1'b1
    } copy_state_e;

    localparam int NUM_FUNC    = 8;
    localparam int NUM_DP      = 4;
    localparam int FN_CANCEL   = 5;
    localparam int FN_RESOURCE = 6;

    localparam int HOST_AW     = 6;
    localparam int HOST_DW     = 32;
    localparam int A_MASK      = 8;
    localparam int A_LEN       = 9;
    localparam int A_SWTRIG    = 10;
    localparam int A_RES_BASE  = 12;
    localparam int MODE_BIT    = 16;
endpackage

// File: rtl/sync_edge_det.sv
module sync_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    logic [2:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[1:0], pin};
    end

    assign rise = sh[1] & ~sh[2];
endmodule

// File: rtl/sync_arm.sv
module sync_arm
    import sync_pkg::*;
#(
    parameter bit IS_DATAPATH = 1'b0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cfg_we,
    input  sync_src_e cfg_src,
    input  logic      ev_a,
    input  logic      ev_b,
    input  logic      ev_sw,
    output logic      upd
);
    arm_state_e state_q, state_d;
    sync_src_e  src_q;
    logic       ev_sel, fire, cfg_ok;

    always_comb begin
        unique case (src_q)
            SRC_PIN_A: ev_sel = ev_a;
            SRC_PIN_B: ev_sel = ev_b;
            SRC_SOFT:  ev_sel = IS_DATAPATH ? 1'b0 : ev_sw;
            default:   ev_sel = 1'b0;
        endcase
    end

    assign fire   = (state_q == ARM_ARMED) && ev_sel;
    assign cfg_ok = (cfg_src != SRC_NEVER) && !(IS_DATAPATH && cfg_src == SRC_SOFT);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARM_UNCFG: if (cfg_we && cfg_ok) state_d = ARM_ARMED;
            ARM_ARMED: begin
                if (cfg_we)    state_d = cfg_ok ? ARM_ARMED : ARM_UNCFG;
                else if (fire) state_d = ARM_UNCFG;
            end
            default:   state_d = ARM_UNCFG;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARM_UNCFG;
            src_q   <= SRC_NEVER;
        end else begin
            state_q <= state_d;
            if (cfg_we) src_q <= cfg_src;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) upd <= 1'b0;
        else        upd <= fire;
    end
endmodule

// File: rtl/coef_copy.sv
module coef_copy
    import sync_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int COEF_W = 16,
    parameter int NBANK  = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LW-1:0]     len,
    input  logic [NBANK-1:0]  mask,
    input  logic              cplx,
    input  logic [COEF_W-1:0] rd_i,
    input  logic [COEF_W-1:0] rd_q,
    output logic [AW-1:0]     rd_addr,
    output logic [NBANK-1:0]  bank_we,
    output logic [AW-1:0]     bank_addr,
    output logic [COEF_W-1:0] wd_i,
    output logic [COEF_W-1:0] wd_q,
    output logic              busy
);
    copy_state_e       state_q, state_d;
    logic [LW-1:0]     cnt_q, last_q, len_eff;
    logic [NBANK-1:0]  mask_q;
    logic              cplx_q;

    assign len_eff = (len > LW'(DEPTH)) ? LW'(DEPTH) : len;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CP_IDLE: if (start && len_eff != '0) state_d = CP_COPY;
            CP_COPY: if (cnt_q == last_q)        state_d = CP_IDLE;
            default: state_d = CP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CP_IDLE;
            cnt_q   <= '0;
            last_q  <= '0;
            mask_q  <= '0;
            cplx_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == CP_IDLE) begin
                cnt_q  <= '0;
                last_q <= len_eff - LW'(1);
                mask_q <= mask;
                cplx_q <= cplx;
            end else begin
                cnt_q <= cnt_q + LW'(1);
            end
        end
    end

    always_comb begin
        busy      = (state_q == CP_COPY);
        rd_addr   = cnt_q[AW-1:0];
        bank_addr = cnt_q[AW-1:0];
        bank_we   = busy ? mask_q : '0;
        wd_i      = rd_i;
        wd_q      = cplx_q ? rd_q : '0;
    end
endmodule

// File: rtl/sync_ctrl_top.sv
module sync_ctrl_top
    import sync_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int COEF_W  = 16,
    parameter int NBANK   = 8,
    parameter int NSTAGE  = 4,
    parameter int CNT_W   = 4,
    parameter int MAX_RES = 8,
    localparam int AW     = $clog2(DEPTH),
    localparam int LW     = $clog2(DEPTH + 1),
    localparam int CAP_W  = $clog2(4 * MAX_RES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    host_we,
    input  logic [HOST_AW-1:0]      host_addr,
    input  logic [HOST_DW-1:0]      host_wdata,
    output logic                    host_stall,
    input  logic                    sync_a,
    input  logic                    sync_b,
    output logic [NUM_FUNC-1:0]     upd_strobe,
    output logic                    run_enable,
    output logic [NBANK-1:0]        bank_we,
    output logic [AW-1:0]           bank_addr,
    output logic [COEF_W-1:0]       bank_wdata_i,
    output logic [COEF_W-1:0]       bank_wdata_q,
    output logic [NSTAGE*CAP_W-1:0] peak_cap
);
    logic                ev_a, ev_b, sw_pulse, busy;
    logic [NUM_DP-1:0]   dp_done;
    logic [NBANK-1:0]    mask_q;
    logic [LW-1:0]       len_q;
    logic                cplx_q;
    logic [2*COEF_W-1:0] shadow [DEPTH];
    logic [AW-1:0]       rd_addr;
    logic                shadow_sel;

    sync_edge_det u_edge_a (.clk(clk), .rst_n(rst_n), .pin(sync_a), .rise(ev_a));
    sync_edge_det u_edge_b (.clk(clk), .rst_n(rst_n), .pin(sync_b), .rise(ev_b));

    for (genvar f = 0; f < NUM_FUNC; f++) begin : g_func
        logic cfg_we;
        assign cfg_we = host_we && (host_addr == HOST_AW'(f));
        sync_arm #(.IS_DATAPATH(f < NUM_DP)) u_arm (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg_we  (cfg_we),
            .cfg_src (sync_src_e'(host_wdata[1:0])),
            .ev_a    (ev_a),
            .ev_b    (ev_b),
            .ev_sw   (sw_pulse),
            .upd     (upd_strobe[f])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_pulse <= 1'b0;
            dp_done  <= '0;
            mask_q   <= '0;
            len_q    <= '0;
            cplx_q   <= 1'b0;
        end else begin
            sw_pulse <= host_we && host_addr == HOST_AW'(A_SWTRIG) && host_wdata[0];
            dp_done  <= dp_done | upd_strobe[NUM_DP-1:0];
            if (host_we && host_addr == HOST_AW'(A_MASK)) mask_q <= host_wdata[NBANK-1:0];
            if (host_we && host_addr == HOST_AW'(A_LEN)) begin
                len_q  <= host_wdata[LW-1:0];
                cplx_q <= host_wdata[MODE_BIT];
            end
        end
    end

    assign run_enable = &dp_done;

    // Shadow RAM: host-written only while no copy is running
    assign shadow_sel = host_addr[HOST_AW-1];
    always_ff @(posedge clk) begin
        if (host_we && shadow_sel && !busy)
            shadow[host_addr[AW-1:0]] <= host_wdata[2*COEF_W-1:0];
    end

    coef_copy #(.DEPTH(DEPTH), .COEF_W(COEF_W), .NBANK(NBANK)) u_copy (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (upd_strobe[FN_CANCEL]),
        .len       (len_q),
        .mask      (mask_q),
        .cplx      (cplx_q),
        .rd_i      (shadow[rd_addr][COEF_W-1:0]),
        .rd_q      (shadow[rd_addr][2*COEF_W-1:COEF_W]),
        .rd_addr   (rd_addr),
        .bank_we   (bank_we),
        .bank_addr (bank_addr),
        .wd_i      (bank_wdata_i),
        .wd_q      (bank_wdata_q),
        .busy      (busy)
    );

    assign host_stall = busy;

    for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
        logic [CNT_W-1:0] staged_q;
        logic [CAP_W-1:0] cap_q;
        logic [CNT_W-1:0] sat;
        assign sat = (staged_q > CNT_W'(MAX_RES)) ? CNT_W'(MAX_RES) : staged_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                staged_q <= '0;
                cap_q    <= '0;
            end else begin
                if (host_we && host_addr == HOST_AW'(A_RES_BASE + s))
                    staged_q <= host_wdata[CNT_W-1:0];
                if (upd_strobe[FN_RESOURCE])
                    cap_q <= CAP_W'(sat) << 2;
            end
        end
        assign peak_cap[s*CAP_W +: CAP_W] = cap_q;
    end
endmodule

// File: rtl/sync_ctrl_chk.sv
module sync_ctrl_chk #(
    parameter int NFN   = 8,
    parameter int NB    = 8,
    parameter int NST   = 4,
    parameter int CW    = 6,
    parameter int CAPMX = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NFN-1:0]    upd_strobe,
    input logic              run_enable,
    input logic [NB-1:0]     bank_we,
    input logic              host_stall,
    input logic [NST*CW-1:0] peak_cap
);
    // R2
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_strobe & $past(upd_strobe)) == '0);

    // R6
    run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_enable |=> run_enable);

    // R6
    run_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_enable) |-> $past(|upd_strobe[3:0]));

    // R8
    we_in_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|bank_we) |-> host_stall);

    // R7
    copy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_stall) |-> $past(upd_strobe[5]));

    // R11
    for (genvar s = 0; s < NST; s++) begin : g_cap
        cap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            peak_cap[s*CW +: CW] <= CW'(CAPMX));
    end
endmodule

bind sync_ctrl_top sync_ctrl_chk #(.NFN(8), .NB(8), .NST(4), .CW(6), .CAPMX(32)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_strobe (upd_strobe),
    .run_enable (run_enable),
    .bank_we    (bank_we),
    .host_stall (host_stall),
    .peak_cap   (peak_cap)
);

// File: tb/test_sync_ctrl_top.sv
module test_sync_ctrl_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] SENT = 32'hDEAD_BEEF;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [5:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        host_stall, sync_a = 1'b0, sync_b = 1'b0, run_enable;
    logic [7:0]  upd_strobe, bank_we;
    logic [3:0]  bank_addr;
    logic [15:0] bank_wdata_i, bank_wdata_q;
    logic [23:0] peak_cap;

    int n_chk = 0, n_fail = 0;
    int cnt [8];
    logic [31:0] bm [8][16];
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_ctrl_top i_sync_ctrl_top (.*);

    initial begin
        for (int b = 0; b < 8; b++) begin
            cnt[b] = 0;
            for (int k = 0; k < 16; k++) bm[b][k] = SENT;
        end
    end

    always @(posedge clk) begin
        if (rst_n) begin
            for (int f = 0; f < 8; f++) if (upd_strobe[f]) cnt[f] = cnt[f] + 1;
            for (int b = 0; b < 8; b++) if (bank_we[b]) bm[b][bank_addr] = {bank_wdata_q, bank_wdata_i};
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = 6'(a); host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic pulse_pin(input bit which_b, input int hold);
        @(negedge clk);
        if (which_b) sync_b = 1'b1; else sync_a = 1'b1;
        repeat (hold) @(negedge clk);
        sync_a = 1'b0; sync_b = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset;
        check(upd_strobe == 0 && run_enable == 0, "R1", {upd_strobe, 7'b0, run_enable}, 0);
        check(bank_we == 0 && host_stall == 0 && peak_cap == 0, "R1", {bank_we, 7'b0, host_stall}, 0);
    endtask

    task automatic t_datapath;
        wr(0, 1); wr(1, 2); wr(2, 1); wr(3, 3);
        pulse_pin(1'b0, 10);
        check(cnt[0] == 1 && cnt[2] == 1, "R2", cnt[0] + cnt[2], 2);
        check(cnt[1] == 0, "R2", cnt[1], 0);
        check(run_enable == 0, "R6", run_enable, 0);
        pulse_pin(1'b1, 3);
        check(cnt[1] == 1, "R2", cnt[1], 1);
        wr(10, 1); repeat (4) @(negedge clk);
        check(cnt[3] == 0, "R4", cnt[3], 0);
        check(run_enable == 0, "R6", run_enable, 0);
        wr(3, 2); pulse_pin(1'b1, 2);
        check(cnt[3] == 1, "R4", cnt[3], 1);
        check(cnt[1] == 1, "R5", cnt[1], 1);
        check(run_enable == 1, "R6", run_enable, 1);
        pulse_pin(1'b0, 2);
        check(cnt[0] == 1 && run_enable == 1, "R5", cnt[0], 1);
    endtask

    task automatic t_ancillary;
        wr(10, 1); repeat (4) @(negedge clk);
        check(cnt[4] == 0, "R5", cnt[4], 0);
        wr(7, 0); wr(10, 1); repeat (4) @(negedge clk);
        check(cnt[7] == 0, "R5", cnt[7], 0);
        wr(4, 3); wr(10, 1); repeat (4) @(negedge clk);
        check(cnt[4] == 1, "R3", cnt[4], 1);
        wr(10, 1); repeat (4) @(negedge clk);
        check(cnt[4] == 1, "R3", cnt[4], 1);
    endtask

    task automatic t_copy;
        bit saw;
        for (int k = 0; k < 8; k++) wr(32 + k, {16'h2000 + 16'(k), 16'h1000 + 16'(k)});
        wr(8, 32'h25); wr(9, 32'h0001_0006); wr(5, 3);
        repeat (3) @(negedge clk);
        check(bm[0][0] == SENT, "R7", bm[0][0], SENT);
        wr(10, 1);
        saw = 1'b0;
        for (int w = 0; w < 10 && !saw; w++) begin
            if (host_stall) saw = 1'b1; else @(negedge clk);
        end
        check(saw, "R10", host_stall, 1);
        host_we = 1'b1; host_addr = 6'd32; host_wdata = 32'hFFFF_FFFF;
        @(negedge clk); host_we = 1'b0;
        repeat (12) @(negedge clk);
        check(host_stall == 0, "R8", host_stall, 0);
        check(bm[0][0] == 32'h2000_1000, "R8", bm[0][0], 32'h2000_1000);
        check(bm[2][5] == 32'h2005_1005, "R9", bm[2][5], 32'h2005_1005);
        check(bm[5][3] == 32'h2003_1003, "R8", bm[5][3], 32'h2003_1003);
        check(bm[0][6] == SENT, "R8", bm[0][6], SENT);
        check(bm[1][0] == SENT && bm[7][0] == SENT, "R8", bm[1][0], SENT);
        wr(8, 32'h02); wr(9, 32'h0000_0002); wr(5, 3); wr(10, 1);
        repeat (10) @(negedge clk);
        check(bm[1][0] == 32'h0000_1000, "R10", bm[1][0], 32'h0000_1000);
        check(bm[1][1] == 32'h0000_1001, "R9", bm[1][1], 32'h0000_1001);
        check(bm[1][2] == SENT, "R8", bm[1][2], SENT);
    endtask

    task automatic t_resource;
        wr(12, 3); wr(13, 12); wr(14, 0); wr(15, 1);
        repeat (2) @(negedge clk);
        check(peak_cap == 0, "R11", peak_cap, 0);
        wr(6, 1); pulse_pin(1'b0, 2);
        check(peak_cap == {6'd4, 6'd0, 6'd32, 6'd12}, "R11", peak_cap, {6'd4, 6'd0, 6'd32, 6'd12});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_datapath();
        t_ancillary();
        t_copy();
        t_resource();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule